// File: doc/BRIEF.md
# Two-Codeword Symbol Interleaver and Lane Distributor

This block sits in the transmit path of a multilane Ethernet coding sublayer. It sits between the scrambled data stream and the PCS lanes. Incoming 10-bit symbols are dealt alternately into two Reed-Solomon message buffers, called codeword A and codeword B. Each buffer holds 514 message symbols. Every symbol accepted into a buffer is also shown on an encoder-facing port, together with the buffer it went to. This lets an external RS(544,514) encoder compute the parity.

The encoder returns 30 parity symbols for each codeword through a simple valid/ready port. While it does so, the input is held off. Once both parity blocks are complete, the block sends out the two 544-symbol codewords over a number of beats. On each beat, every PCS lane receives one symbol. The lanes alternate between the codewords, and each lane also alternates from beat to beat, so codeword ownership forms a checkerboard. A receiver that can repair 15 symbols per codeword therefore sees a burst on one lane spread over both codewords.

The lane count is a parameter, 8 or 16. It sets the number of beats per codeword pair: 136 beats for 8 lanes and 68 beats for 16 lanes.

Top module: `sym_lane_interleaver`

## Requirements
- R1: Accepted input symbols alternate between codewords, and `enc_sel` marks the target (0 = A, 1 = B). The first symbol after reset, and the first symbol of every later codeword pair, goes to A.
- R2: `in_ready` drops in the cycle after the 1028th message symbol of a pair is accepted. It stays low through the parity intake and the emission of that pair, and no symbol is accepted in that time.
- R3: `enc_valid` is high exactly in the cycles where an input symbol is accepted. In those cycles `enc_sym` equals `in_sym`.
- R4: `par_ready` is high only while parity is awaited. The parity symbols for each codeword (`par_sel` 0 = A, 1 = B) are taken in arrival order and fill codeword positions 514 to 543. Parity for A and B may arrive in any interleaving.
- R5: A parity symbol offered for a codeword that already holds 30 parity symbols is ignored and changes no output symbol.
- R6: `lane_valid` rises in the cycle after the last parity symbol of a pair is accepted. It stays high for exactly 1088/LANES beats, and `lane_start` is high on the first of those beats only. LANES must be 8 or 16.
- R7: On beat k, lane l sits on bits [10l+9:10l] of `lane_data`. It carries codeword (l+k) mod 2 (0 = A), at symbol position k·LANES/2 + floor(l/2). Even lanes therefore start with A and odd lanes with B.
- R8: In the cycle after the final beat, `lane_valid` is low and `in_ready` is high. An input symbol offered in that cycle is accepted as A position 0 of the next pair, which is emitted again from lane 0.
- R9: While reset is asserted and right after it, `in_ready` is high and `par_ready`, `lane_valid`, `lane_start` and `enc_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input symbol offered |
| in_sym | input | SYM_W | Input symbol |
| in_ready | output | 1 | Block accepts input symbols |
| enc_valid | output | 1 | Message symbol accepted this cycle |
| enc_sel | output | 1 | Codeword of the accepted symbol, 0 = A, 1 = B |
| enc_sym | output | SYM_W | Accepted message symbol |
| par_valid | input | 1 | Parity symbol offered |
| par_sel | input | 1 | Codeword of the parity symbol, 0 = A, 1 = B |
| par_sym | input | SYM_W | Parity symbol |
| par_ready | output | 1 | Block accepts parity symbols |
| lane_valid | output | 1 | Lane beat present |
| lane_start | output | 1 | First beat of a codeword pair |
| lane_data | output | LANES*SYM_W | One symbol per lane, lane 0 in the low bits |

## Verification
Two events meet in one cycle: the final emission beat ends, and the first input of the next pair can be accepted in the very next cycle, because `in_ready` returns at once. The bench provokes this by keeping `in_valid` high with a marked symbol throughout the parity intake and the emission. During that time it checks that `enc_valid` stays low. In the cycle after the last beat it checks that the marked symbol is accepted with `enc_sel` = A. The next pair's emission must then show that symbol on lane 0 at beat 0.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

   typedef enum logic [1:0] {
      PH_COLLECT = 2'd0,
      PH_PARITY  = 2'd1,
      PH_EMIT    = 2'd2
   } ilv_phase_e;

   // position inside a codeword of the symbol that lane `lane` carries on beat `beat`
   function automatic int unsigned slot_of(input int unsigned beat,
                                           input int unsigned lane,
                                           input int unsigned lanes);
      return beat * (lanes / 2) + lane / 2;
   endfunction

endpackage

// File: rtl/ilv_ctrl.sv
module ilv_ctrl
   import ilv_pkg::*;
#(
   parameter int MSG_SYMS = 514,
   parameter int PAR_SYMS = 30,
   parameter int LANES    = 16,
   localparam int CW      = MSG_SYMS + PAR_SYMS,
   localparam int STEPS   = 2 * CW / LANES,
   localparam int IDX_W   = $clog2(CW),
   localparam int ST_W    = $clog2(STEPS),
   localparam int PC_W    = $clog2(PAR_SYMS + 1),
   localparam int CNT_W   = $clog2(2 * MSG_SYMS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             par_valid,
   input  logic             par_sel,
   output logic             in_ready,
   output logic             par_ready,
   output logic             lane_valid,
   output logic             lane_start,
   output logic             msg_acc,
   output logic             msg_sel,
   output logic [IDX_W-1:0] msg_idx,
   output logic             par_acc,
   output logic [IDX_W-1:0] par_slot,
   output logic [ST_W-1:0]  beat
);

   localparam logic [CNT_W-1:0] MSG_LAST  = CNT_W'(2 * MSG_SYMS - 1);
   localparam logic [PC_W-1:0]  PAR_FULL  = PC_W'(PAR_SYMS);
   localparam logic [ST_W-1:0]  BEAT_LAST = ST_W'(STEPS - 1);

   ilv_phase_e       phase_q;
   logic [CNT_W-1:0] msg_cnt_q;
   logic [PC_W-1:0]  pca_q, pcb_q, pca_n, pcb_n;
   logic [ST_W-1:0]  beat_q;
   logic             room;

   assign in_ready   = (phase_q == PH_COLLECT);
   assign par_ready  = (phase_q == PH_PARITY);
   assign lane_valid = (phase_q == PH_EMIT);
   assign lane_start = lane_valid && (beat_q == '0);
   assign beat       = beat_q;

   assign msg_acc = in_valid && in_ready;
   assign msg_sel = msg_cnt_q[0];
   assign msg_idx = IDX_W'(msg_cnt_q >> 1);

   assign room     = par_sel ? (pcb_q != PAR_FULL) : (pca_q != PAR_FULL);
   assign par_acc  = par_valid && par_ready && room;
   assign par_slot = IDX_W'(MSG_SYMS) + IDX_W'(par_sel ? pcb_q : pca_q);
   assign pca_n    = pca_q + PC_W'(par_acc && !par_sel);
   assign pcb_n    = pcb_q + PC_W'(par_acc && par_sel);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q   <= PH_COLLECT;
         msg_cnt_q <= '0;
         pca_q     <= '0;
         pcb_q     <= '0;
         beat_q    <= '0;
      end else begin
         unique case (phase_q)
            PH_COLLECT: if (msg_acc) begin
               if (msg_cnt_q == MSG_LAST) begin
                  msg_cnt_q <= '0;
                  phase_q   <= PH_PARITY;
               end else begin
                  msg_cnt_q <= msg_cnt_q + 1'b1;
               end
            end
            PH_PARITY: begin
               pca_q <= pca_n;
               pcb_q <= pcb_n;
               if (pca_n == PAR_FULL && pcb_n == PAR_FULL) begin
                  beat_q  <= '0;
                  phase_q <= PH_EMIT;
               end
            end
            PH_EMIT: begin
               if (beat_q == BEAT_LAST) begin
                  beat_q  <= '0;
                  pca_q   <= '0;
                  pcb_q   <= '0;
                  phase_q <= PH_COLLECT;
               end else begin
                  beat_q <= beat_q + 1'b1;
               end
            end
            default: phase_q <= PH_COLLECT;
         endcase
      end
   end

endmodule

// File: rtl/ilv_sym_store.sv
module ilv_sym_store #(
   parameter int SYM_W = 10,
   parameter int DEPTH = 544,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic                     clk,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [SYM_W-1:0]         wr_sym,
   output logic [DEPTH*SYM_W-1:0]   contents
);

   always_ff @(posedge clk) begin
      if (wr_en) contents[wr_idx*SYM_W +: SYM_W] <= wr_sym;
   end

endmodule

// File: rtl/ilv_lane_map.sv
module ilv_lane_map
   import ilv_pkg::*;
#(
   parameter int SYM_W = 10,
   parameter int DEPTH = 544,
   parameter int LANES = 16,
   localparam int STEPS = 2 * DEPTH / LANES,
   localparam int IDX_W = $clog2(DEPTH),
   localparam int ST_W  = $clog2(STEPS)
) (
   input  logic [ST_W-1:0]          beat,
   input  logic [DEPTH*SYM_W-1:0]   cw_a,
   input  logic [DEPTH*SYM_W-1:0]   cw_b,
   output logic [LANES*SYM_W-1:0]   lane_data
);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam logic ODD = 1'(l % 2);
      logic             take_b;
      logic [IDX_W-1:0] slot;
      assign take_b = beat[0] ^ ODD;
      assign slot   = IDX_W'(slot_of(32'(beat), l, LANES));
      assign lane_data[l*SYM_W +: SYM_W] = take_b ? cw_b[slot*SYM_W +: SYM_W]
                                                  : cw_a[slot*SYM_W +: SYM_W];
   end

endmodule

// File: rtl/sym_lane_interleaver.sv
module sym_lane_interleaver #(
   parameter int SYM_W    = 10,
   parameter int MSG_SYMS = 514,
   parameter int PAR_SYMS = 30,
   parameter int LANES    = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_valid,
   input  logic [SYM_W-1:0]       in_sym,
   output logic                   in_ready,
   output logic                   enc_valid,
   output logic                   enc_sel,
   output logic [SYM_W-1:0]       enc_sym,
   input  logic                   par_valid,
   input  logic                   par_sel,
   input  logic [SYM_W-1:0]       par_sym,
   output logic                   par_ready,
   output logic                   lane_valid,
   output logic                   lane_start,
   output logic [LANES*SYM_W-1:0] lane_data
);

   localparam int CW    = MSG_SYMS + PAR_SYMS;
   localparam int STEPS = 2 * CW / LANES;
   localparam int IDX_W = $clog2(CW);
   localparam int ST_W  = $clog2(STEPS);

   // R6: lane count must be one of the two supported widths
   if (!(LANES == 8 || LANES == 16)) begin : g_bad_lanes
      $error("LANES must be 8 or 16");
   end
   if ((CW % (LANES / 2)) != 0) begin : g_bad_split
      $error("codeword length must divide evenly over half the lanes");
   end
   if (SYM_W < 1 || PAR_SYMS < 1 || MSG_SYMS < 1) begin : g_bad_sizes
      $error("symbol width and codeword sizes must be positive");
   end

   logic             msg_acc, msg_sel, par_acc;
   logic [IDX_W-1:0] msg_idx, par_slot, wr_idx;
   logic [SYM_W-1:0] wr_sym;
   logic [ST_W-1:0]  beat;
   logic [CW*SYM_W-1:0] cw_flat [2];

   ilv_ctrl #(
      .MSG_SYMS(MSG_SYMS), .PAR_SYMS(PAR_SYMS), .LANES(LANES)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .par_valid(par_valid), .par_sel(par_sel),
      .in_ready(in_ready), .par_ready(par_ready),
      .lane_valid(lane_valid), .lane_start(lane_start),
      .msg_acc(msg_acc), .msg_sel(msg_sel), .msg_idx(msg_idx),
      .par_acc(par_acc), .par_slot(par_slot), .beat(beat)
   );

   assign enc_valid = msg_acc;
   assign enc_sel   = msg_sel;
   assign enc_sym   = in_sym;

   // message and parity writes never share a cycle: they belong to different phases
   assign wr_idx = msg_acc ? msg_idx : par_slot;
   assign wr_sym = msg_acc ? in_sym  : par_sym;

   for (genvar g = 0; g < 2; g++) begin : g_cw
      localparam logic WHICH = 1'(g);
      logic wr_en;
      assign wr_en = (msg_acc && (msg_sel == WHICH)) || (par_acc && (par_sel == WHICH));
      ilv_sym_store #(.SYM_W(SYM_W), .DEPTH(CW)) u_store (
         .clk(clk), .wr_en(wr_en), .wr_idx(wr_idx), .wr_sym(wr_sym),
         .contents(cw_flat[g])
      );
   end

   ilv_lane_map #(.SYM_W(SYM_W), .DEPTH(CW), .LANES(LANES)) u_map (
      .beat(beat), .cw_a(cw_flat[0]), .cw_b(cw_flat[1]), .lane_data(lane_data)
   );

endmodule

// File: rtl/ilv_chk.sv
module ilv_chk #(
   parameter int SYM_W    = 10,
   parameter int MSG_SYMS = 514,
   parameter int PAR_SYMS = 30,
   parameter int LANES    = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [SYM_W-1:0] in_sym,
   input logic             in_ready,
   input logic             enc_valid,
   input logic             enc_sel,
   input logic [SYM_W-1:0] enc_sym,
   input logic             par_ready,
   input logic             lane_valid,
   input logic             lane_start
);

   localparam int STEPS = 2 * (MSG_SYMS + PAR_SYMS) / LANES;
   localparam int ST_W  = $clog2(STEPS);
   localparam int AC_W  = $clog2(2 * MSG_SYMS);

   logic            sel_exp;
   logic [AC_W-1:0] acc_cnt;
   logic [ST_W-1:0] beat_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_exp  <= 1'b0;
         acc_cnt  <= '0;
         beat_cnt <= '0;
      end else begin
         if (enc_valid) begin
            sel_exp <= !sel_exp;
            acc_cnt <= (acc_cnt == AC_W'(2 * MSG_SYMS - 1)) ? '0 : acc_cnt + 1'b1;
         end
         if (lane_valid)
            beat_cnt <= (beat_cnt == ST_W'(STEPS - 1)) ? '0 : beat_cnt + 1'b1;
      end
   end

   // R3
   enc_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> (in_valid && in_ready && enc_sym == in_sym));

   // R1
   enc_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      enc_valid |-> (enc_sel == sel_exp));

   // R4
   phase_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({in_ready, par_ready, lane_valid}) == 1);

   // R2
   stall_after_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ready) |-> (acc_cnt == '0 && $past(enc_valid)));

   // R2
   resume_after_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> $past(lane_valid));

   // R6
   start_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lane_valid |-> (lane_start == (beat_cnt == '0)));

   // R6
   beat_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lane_valid) |-> ($past(beat_cnt) == ST_W'(STEPS - 1)));

   // R8
   reopen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lane_valid) |-> in_ready);

endmodule

bind sym_lane_interleaver ilv_chk #(
   .SYM_W(SYM_W), .MSG_SYMS(MSG_SYMS), .PAR_SYMS(PAR_SYMS), .LANES(LANES)
) u_ilv_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
   .in_ready(in_ready), .enc_valid(enc_valid), .enc_sel(enc_sel), .enc_sym(enc_sym),
   .par_ready(par_ready), .lane_valid(lane_valid), .lane_start(lane_start)
);

// File: tb/test_sym_lane_interleaver.sv
module test_sym_lane_interleaver;

   localparam int SW    = 10;
   localparam int MSG   = 514;
   localparam int PAR   = 30;
   localparam int LANES = 16;
   localparam int CW    = MSG + PAR;
   localparam int STEPS = 2 * CW / LANES;
   localparam int HALF  = LANES / 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [SW-1:0] in_sym = '0;
   logic par_valid = 1'b0;
   logic par_sel = 1'b0;
   logic [SW-1:0] par_sym = '0;
   logic in_ready, enc_valid, enc_sel, par_ready, lane_valid, lane_start;
   logic [SW-1:0] enc_sym;
   logic [LANES*SW-1:0] lane_data;

   int n_tests = 0;
   int n_fail  = 0;
   logic [SW-1:0] exp_a [CW];
   logic [SW-1:0] exp_b [CW];
   bit            carried = 1'b0;
   logic [SW-1:0] carry_sym = '0;

   always #4 clk = !clk;

   sym_lane_interleaver #(.SYM_W(SW), .MSG_SYMS(MSG), .PAR_SYMS(PAR), .LANES(LANES))
   i_sym_lane_interleaver (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym), .in_ready(in_ready),
      .enc_valid(enc_valid), .enc_sel(enc_sel), .enc_sym(enc_sym),
      .par_valid(par_valid), .par_sel(par_sel), .par_sym(par_sym), .par_ready(par_ready),
      .lane_valid(lane_valid), .lane_start(lane_start), .lane_data(lane_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [SW-1:0] msgv(input int seed, input int t);
      return SW'((t * 37 + seed * 101 + 5) % 1024);
   endfunction

   task automatic t_reset();
      #1;
      chk(in_ready && !par_ready && !lane_valid && !lane_start && !enc_valid,
          "R9 outputs during reset", {in_ready, par_ready, lane_valid, lane_start, enc_valid}, 5'b10000);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk(in_ready && !par_ready && !lane_valid && !lane_start && !enc_valid,
          "R9 outputs after reset", {in_ready, par_ready, lane_valid, lane_start, enc_valid}, 5'b10000);
   endtask

   // feeds one pair of messages; the carried symbol (if any) was already taken as A[0]
   task automatic feed(input int seed, input bit gaps, input bit hold);
      int bad = 0;
      int bad_sel = 0;
      int first_t = 0;
      if (carried) begin
         exp_a[0] = carry_sym;
         carried  = 1'b0;
         first_t  = 1;
      end
      for (int t = first_t; t < 2 * MSG; t++) begin
         if (gaps && (t % 5 == 2)) begin
            @(negedge clk); in_valid = 1'b0; #1;
            if (enc_valid) bad++;
         end
         @(negedge clk);
         in_valid = 1'b1;
         in_sym   = msgv(seed, t);
         #1;
         if (!in_ready || !enc_valid || enc_sym != in_sym) bad++;
         if (enc_sel != 1'(t % 2)) bad_sel++;
         if (t % 2 == 0) exp_a[t / 2] = in_sym;
         else            exp_b[t / 2] = in_sym;
      end
      chk(bad == 0, "R3 encoder mirror of accepted symbols", bad, 0);
      chk(bad_sel == 0, "R1 alternating A/B target", bad_sel, 0);
      @(negedge clk);
      if (hold) begin
         carry_sym = 10'h2A5;
         in_sym    = carry_sym;
         carried   = 1'b1;
      end else begin
         in_valid = 1'b0;
      end
      #1;
      chk(!in_ready && !enc_valid, "R2 input stalled after 1028 symbols",
          {in_ready, enc_valid}, 0);
   endtask

   // mode 0: all of A, two surplus A symbols, then all of B; mode 1: B and A interleaved, B first
   task automatic parity(input int seed, input int mode);
      int bad = 0;
      int total = (mode == 0) ? 2 * PAR + 2 : 2 * PAR;
      for (int n = 0; n < total; n++) begin
         bit sel;
         int j;
         bit extra;
         if (mode == 0) begin
            sel   = (n >= PAR + 2);
            j     = sel ? n - PAR - 2 : n;
            extra = (n >= PAR) && (n < PAR + 2);
         end else begin
            sel   = (n % 2 == 0);
            j     = n / 2;
            extra = 1'b0;
         end
         @(negedge clk);
         par_valid = 1'b1;
         par_sel   = sel;
         par_sym   = extra ? SW'(10'h3FF - n) : SW'(10'h200 ^ (j * 13 + seed));
         #1;
         if (!par_ready || in_ready || enc_valid || lane_valid) bad++;
         if (!extra) begin
            if (sel) exp_b[MSG + j] = par_sym;
            else     exp_a[MSG + j] = par_sym;
         end
      end
      chk(bad == 0, (mode == 0) ? "R4 parity intake (A then B)" : "R4 parity intake (interleaved)", bad, 0);
      @(negedge clk);
      par_valid = 1'b0;
   endtask

   task automatic emit(input bit hold, input bit surplus_sent);
      int bad_stall = 0;
      #1;
      chk(lane_valid, "R6 emission starts after last parity", lane_valid, 1);
      for (int k = 0; k < STEPS; k++) begin
         int bad = 0;
         if (k > 0) begin @(negedge clk); #1; end
         if (!lane_valid || lane_start != (k == 0)) bad++;
         if (in_ready || enc_valid || par_ready) bad_stall++;
         for (int l = 0; l < LANES; l++) begin
            int idx = k * HALF + l / 2;
            logic [SW-1:0] want;
            logic [SW-1:0] got;
            want = ((l + k) % 2 == 1) ? exp_b[idx] : exp_a[idx];
            got  = lane_data[l*SW +: SW];
            if (got != want) begin
               if (bad < 2)
                  $display("  beat %0d lane %0d got %0d want %0d", k, l, got, want);
               bad++;
            end
         end
         if (surplus_sent && k >= (MSG / HALF))
            chk(bad == 0, "R5 surplus parity ignored", bad, 0);
         else
            chk(bad == 0, "R7 checkerboard lane placement", bad, 0);
      end
      chk(bad_stall == 0, "R2 no intake during emission", bad_stall, 0);
      @(negedge clk); #1;
      chk(!lane_valid && in_ready, "R8 reopen after final beat", {lane_valid, in_ready}, 2'b01);
      chk(!lane_valid, "R6 beat count equals 1088/LANES", lane_valid, 0);
      if (hold)
         chk(enc_valid && !enc_sel && enc_sym == carry_sym,
             "R8 held symbol taken as A[0]", {enc_valid, enc_sel}, 2'b10);
   endtask

   task automatic t_plain_pair();
      feed(1, 1'b0, 1'b0);
      parity(1, 0);
      emit(1'b0, 1'b1);
   endtask

   task automatic t_gaps_and_hold();
      feed(2, 1'b1, 1'b1);
      parity(2, 1);
      emit(1'b1, 1'b0);
   endtask

   task automatic t_carried_pair();
      feed(3, 1'b0, 1'b0);
      parity(3, 1);
      emit(1'b0, 1'b0);
   endtask

   initial begin
      t_reset();
      t_plain_pair();
      t_gaps_and_hold();
      t_carried_pair();
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule